// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block tracks the coherence state of every line in one private cache that sits on a shared snooping bus. A small direct-mapped array holds a tag and a two-bit state for each line. The states are Invalid, Shared, Exclusive and Modified. Local read and write requests from the processor are answered at once when the line state allows it. Otherwise the block requests the bus and issues a read, a read-for-ownership, an invalidate or a write-back once it holds the grant. Requests that other caches place on the bus are snooped in every cycle. They can lower the state of a held line, and they raise a shared response and a write-back indication one cycle later.

A read miss installs the line Exclusive when no other cache answers with the shared response. A later local write to that line then changes it to Modified with no bus transaction. Data storage, memory timing and arbitration between masters are outside this block. The bus is modelled as a request and grant pair. The local requester holds its request stable until `lreq_done`. The bus places no snoop in the cycle that follows a read this cache issues, because that cycle is the response phase.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset every line is Invalid and `lreq_done`, `bus_req`, `bus_cmd_valid`, `snp_shared_out` and `snp_wb_out` are low, so the first read of any address goes to the bus.
- R2: A local read whose tag matches a line in Shared, Exclusive or Modified completes in the cycle it is presented (`lreq_done` high), with no bus request.
- R3: A read miss raises `bus_req`. In the grant cycle it issues command code 0 (read) with the request address. In the next cycle it samples `bus_shared_in`, installs the line Shared if that input is 1 and Exclusive if it is 0, and completes.
- R4: A local write that hits a Modified or Exclusive line completes in the same cycle with no bus traffic. An Exclusive line becomes Modified.
- R5: A write that hits a Shared line issues code 2 (invalidate) in its grant cycle. A write to an absent or Invalid line issues code 1 (read-for-ownership). In both cases the line becomes Modified and the write completes in that grant cycle.
- R6: A snooped read (code 0) that matches a valid line raises `snp_shared_out` one cycle later. A Modified line also raises `snp_wb_out` and goes to Shared. An Exclusive line goes to Shared.
- R7: A snooped read-for-ownership (code 1) or invalidate (code 2) that matches a valid line moves it to Invalid. If the line was Modified, `snp_wb_out` rises one cycle later.
- R8: A miss whose index holds a Modified line with another tag first issues code 3 (write-back) with the victim's address, then issues its own fetch. Shared or Exclusive victims are replaced with no write-back.
- R9: In a cycle where a snoop targets the same index as the pending local request, the local request neither issues a bus command nor completes, even with the grant present. It goes ahead in a later cycle.
- R10: A snooped write-back (code 3), and any snoop whose tag matches no valid line, changes no state and raises neither response output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present, held until done |
| lreq_write | input | 1 | 1 = write, 0 = read |
| lreq_addr | input | AW | Line address of the local request |
| lreq_done | output | 1 | Local request completes this cycle |
| bus_req | output | 1 | Bus wanted |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd_valid | output | 1 | Command placed on the bus this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr | output | AW | Address of the issued command |
| bus_shared_in | input | 1 | Other caches' shared response, sampled the cycle after a read |
| snp_valid | input | 1 | Snooped request present |
| snp_cmd | input | 2 | Snooped command code, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped line address |
| snp_shared_out | output | 1 | This cache held the snooped read line (one cycle later) |
| snp_wb_out | output | 1 | This cache flushes a Modified line (one cycle later) |

## Verification
The assertions check the following on every cycle: that a read fetch completes in the cycle after it is issued, that a completed write leaves its line Modified, that a write-back leaves the victim slot Invalid, that a shared response follows only a snooped read, and that a matching ownership snoop invalidates its line. The bench scenarios are needed for the rest. They show that the Exclusive fill is chosen only when no sharer answers and that a later write upgrades silently. They cover the victim write-back ordering and its address, the one-cycle stall when a snoop collides with a local request, and snoops that must leave everything untouched.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_st_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RFO = 2'd1,
    CMD_INV = 2'd2,
    CMD_WB  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_REQ  = 2'd1,
    LS_RESP = 2'd2
  } loc_fsm_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int NL = 4,
  parameter int IW = 2,
  parameter int TW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     snp_we,
  input  logic [IW-1:0]            snp_idx,
  input  mesi_st_e                 snp_st,
  input  logic                     loc_we,
  input  logic [IW-1:0]            loc_idx,
  input  logic [TW-1:0]            loc_tag,
  input  mesi_st_e                 loc_st,
  output logic [NL-1:0][TW-1:0]    tag_o,
  output mesi_st_e [NL-1:0]        st_o
);

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic            s_sel;
    logic            l_sel;
    logic            tag_en;
    mesi_st_e        st_q;
    mesi_st_e        st_d;
    logic [TW-1:0]   tag_q;

    assign s_sel  = snp_we && (snp_idx == IW'(i));
    assign l_sel  = loc_we && (loc_idx == IW'(i));
    assign tag_en = l_sel && !s_sel;

    // snoop update wins over a local update of the same slot
    always_comb begin
      st_d = st_q;
      if (s_sel)      st_d = snp_st;
      else if (l_sel) st_d = loc_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_I;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (tag_en) tag_q <= loc_tag;
    end

    assign st_o[i]  = st_q;
    assign tag_o[i] = tag_q;
  end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int AW = 8,
  parameter int NL = 4,
  parameter int IW = 2,
  parameter int TW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snp_valid,
  input  logic [1:0]             snp_cmd,
  input  logic [AW-1:0]          snp_addr,
  input  logic [NL-1:0][TW-1:0]  tag_i,
  input  mesi_st_e [NL-1:0]      st_i,
  output logic                   upd_we,
  output logic [IW-1:0]          upd_idx,
  output mesi_st_e               upd_st,
  output logic                   shared_o,
  output logic                   wb_o
);

  logic [TW-1:0] s_tag;
  mesi_st_e      cur;
  logic          hit;
  logic          sh_d, wb_d, sh_q, wb_q;
  bus_cmd_e      op;

  assign upd_idx = snp_addr[IW-1:0];
  assign s_tag   = snp_addr[AW-1:IW];
  assign cur     = st_i[upd_idx];
  assign hit     = (cur != ST_I) && (tag_i[upd_idx] == s_tag);
  assign op      = bus_cmd_e'(snp_cmd);

  always_comb begin
    upd_we = 1'b0;
    upd_st = cur;
    sh_d   = 1'b0;
    wb_d   = 1'b0;
    if (snp_valid && hit) begin
      case (op)
        CMD_RD: begin
          upd_we = 1'b1;
          upd_st = ST_S;
          sh_d   = 1'b1;
          wb_d   = (cur == ST_M);
        end
        CMD_RFO, CMD_INV: begin
          upd_we = 1'b1;
          upd_st = ST_I;
          wb_d   = (cur == ST_M);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
      wb_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      wb_q <= wb_d;
    end
  end

  assign shared_o = sh_q;
  assign wb_o     = wb_q;

  // R6: a shared response only ever follows a snooped read
  p_share_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shared_o |-> $past(snp_valid && snp_cmd == 2'd0));

  // R7: a matching ownership snoop leaves the slot Invalid
  p_rfo_invalidates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && hit && (snp_cmd == 2'd1 || snp_cmd == 2'd2))
      |=> st_i[$past(upd_idx)] == ST_I);

endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
  import mesi_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_valid,
  input  logic          lreq_write,
  input  logic [AW-1:0] lreq_addr,
  output logic          lreq_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_cmd_valid,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared_out,
  output logic          snp_wb_out
);

  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;

  logic [NL-1:0][TW-1:0] line_tag;
  mesi_st_e [NL-1:0]     line_st;

  logic          s_we;
  logic [IW-1:0] s_idx;
  mesi_st_e      s_st;

  logic [IW-1:0] l_idx;
  logic [TW-1:0] l_tag;
  logic [TW-1:0] cur_tag;
  mesi_st_e      cur_st;
  logic          tag_eq, l_hit, blocked;

  loc_fsm_e      fsm_q, fsm_d;
  logic          l_we;
  logic [TW-1:0] l_wtag;
  mesi_st_e      l_wst;
  bus_cmd_e      cmd;

  mesi_line_array #(.NL(NL), .IW(IW), .TW(TW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .snp_we  (s_we),
    .snp_idx (s_idx),
    .snp_st  (s_st),
    .loc_we  (l_we),
    .loc_idx (l_idx),
    .loc_tag (l_wtag),
    .loc_st  (l_wst),
    .tag_o   (line_tag),
    .st_o    (line_st)
  );

  mesi_snoop_unit #(.AW(AW), .NL(NL), .IW(IW), .TW(TW)) u_snoop (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .tag_i     (line_tag),
    .st_i      (line_st),
    .upd_we    (s_we),
    .upd_idx   (s_idx),
    .upd_st    (s_st),
    .shared_o  (snp_shared_out),
    .wb_o      (snp_wb_out)
  );

  assign l_idx   = lreq_addr[IW-1:0];
  assign l_tag   = lreq_addr[AW-1:IW];
  assign cur_tag = line_tag[l_idx];
  assign cur_st  = line_st[l_idx];
  assign tag_eq  = (cur_tag == l_tag);
  assign l_hit   = tag_eq && (cur_st != ST_I);
  // a snoop to the same slot holds the local side for this cycle
  assign blocked = snp_valid && (snp_addr[IW-1:0] == l_idx);

  always_comb begin
    fsm_d         = fsm_q;
    lreq_done     = 1'b0;
    bus_req       = (fsm_q == LS_REQ);
    bus_cmd_valid = 1'b0;
    cmd           = CMD_RD;
    bus_addr      = lreq_addr;
    l_we          = 1'b0;
    l_wst         = cur_st;
    l_wtag        = l_tag;
    case (fsm_q)
      LS_IDLE: begin
        if (lreq_valid && !blocked) begin
          if (l_hit && !lreq_write) begin
            lreq_done = 1'b1;
          end else if (l_hit && (cur_st == ST_M || cur_st == ST_E)) begin
            lreq_done = 1'b1;
            l_we      = 1'b1;
            l_wst     = ST_M;
          end else begin
            fsm_d = LS_REQ;
          end
        end
      end
      LS_REQ: begin
        if (bus_gnt && !blocked) begin
          bus_cmd_valid = 1'b1;
          if (cur_st == ST_M && !tag_eq) begin
            cmd      = CMD_WB;
            bus_addr = {cur_tag, l_idx};
            l_we     = 1'b1;
            l_wst    = ST_I;
            l_wtag   = cur_tag;
          end else if (lreq_write) begin
            cmd       = (l_hit && cur_st == ST_S) ? CMD_INV : CMD_RFO;
            l_we      = 1'b1;
            l_wst     = ST_M;
            lreq_done = 1'b1;
            fsm_d     = LS_IDLE;
          end else begin
            cmd   = CMD_RD;
            fsm_d = LS_RESP;
          end
        end
      end
      LS_RESP: begin
        lreq_done = 1'b1;
        l_we      = 1'b1;
        l_wst     = bus_shared_in ? ST_S : ST_E;
        fsm_d     = LS_IDLE;
      end
      default: fsm_d = LS_IDLE;
    endcase
  end

  assign bus_cmd = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsm_q <= LS_IDLE;
    else        fsm_q <= fsm_d;
  end

  // R3: an issued fetch completes in the following cycle
  p_fill_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd == 2'd0) |=> lreq_done);

  // R5: a completed write leaves its line Modified
  p_write_leaves_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_done && lreq_write) |=> line_st[$past(l_idx)] == ST_M);

  // R8: after a write-back the slot is free and the fetch is still pending
  p_victim_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd == 2'd3) |=> (line_st[$past(l_idx)] == ST_I) && bus_req);

endmodule

// File: tb/mesi_line_ctl_bench.sv
module mesi_line_ctl_bench;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lreq_valid, lreq_write;
  logic [AW-1:0] lreq_addr;
  logic          lreq_done, bus_req, bus_gnt, bus_cmd_valid;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          bus_shared_in, snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_shared_out, snp_wb_out;

  int checks = 0;
  int errors = 0;

  mesi_line_ctl #(.AW(AW), .IW(IW)) u_mesi_line_ctl (
    .clk(clk), .rst_n(rst_n),
    .lreq_valid(lreq_valid), .lreq_write(lreq_write), .lreq_addr(lreq_addr),
    .lreq_done(lreq_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared_out(snp_shared_out), .snp_wb_out(snp_wb_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // states: 0 invalid, 1 shared, 2 exclusive, 3 modified
  int mt[NL], ms[NL], pt[NL], ps[NL];
  int mmode, pmode, msh, mwb, psh, pwb;
  bit pend;

  task automatic model_eval();
    int li, lt, si, st;
    bit hit, blk, e_done, e_req, e_cv;
    int e_cmd, e_addr;
    li = int'(lreq_addr) % NL;  lt = int'(lreq_addr) / NL;
    si = int'(snp_addr) % NL;   st = int'(snp_addr) / NL;
    blk = snp_valid && (si == li);
    hit = (ms[li] != 0) && (mt[li] == lt);
    foreach (mt[k]) begin pt[k] = mt[k]; ps[k] = ms[k]; end
    pmode = mmode; psh = 0; pwb = 0;
    e_done = 0; e_req = (mmode == 1); e_cv = 0; e_cmd = 0; e_addr = 0;
    if (mmode == 0) begin
      if (lreq_valid && !blk) begin
        if (hit && (!lreq_write || ms[li] >= 2)) begin
          e_done = 1;
          if (lreq_write) ps[li] = 3;
        end else pmode = 1;
      end
    end else if (mmode == 1) begin
      if (bus_gnt && !blk) begin
        e_cv = 1;
        if (ms[li] == 3 && mt[li] != lt) begin
          e_cmd = 3; e_addr = mt[li] * NL + li; ps[li] = 0;
        end else if (lreq_write) begin
          e_cmd = (hit && ms[li] == 1) ? 2 : 1; e_addr = int'(lreq_addr);
          ps[li] = 3; pt[li] = lt; e_done = 1; pmode = 0;
        end else begin
          e_cmd = 0; e_addr = int'(lreq_addr); pmode = 2;
        end
      end
    end else begin
      e_done = 1; ps[li] = bus_shared_in ? 1 : 2; pt[li] = lt; pmode = 0;
    end
    if (snp_valid && ms[si] != 0 && mt[si] == st) begin
      if (snp_cmd == 2'd0) begin psh = 1; pwb = (ms[si] == 3); ps[si] = 1; end
      else if (snp_cmd != 2'd3) begin pwb = (ms[si] == 3); ps[si] = 0; end
    end
    pend = 1;
    chk(lreq_done == e_done, "R2", "lockstep lreq_done", int'(lreq_done), int'(e_done));
    chk(bus_req == e_req, "R3", "lockstep bus_req", int'(bus_req), int'(e_req));
    chk(bus_cmd_valid == e_cv, "R5", "lockstep bus_cmd_valid", int'(bus_cmd_valid), int'(e_cv));
    if (e_cv) begin
      chk(int'(bus_cmd) == e_cmd, "R5", "lockstep bus_cmd", int'(bus_cmd), e_cmd);
      chk(int'(bus_addr) == e_addr, "R8", "lockstep bus_addr", int'(bus_addr), e_addr);
    end
    chk(snp_shared_out == msh[0], "R6", "lockstep snp_shared_out", int'(snp_shared_out), msh);
    chk(snp_wb_out == mwb[0], "R7", "lockstep snp_wb_out", int'(snp_wb_out), mwb);
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n) model_eval();
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ms[k]) begin ms[k] = 0; mt[k] = 0; end
      mmode = 0; msh = 0; mwb = 0; pend = 0;
    end else if (pend) begin
      foreach (ms[k]) begin ms[k] = ps[k]; mt[k] = pt[k]; end
      mmode = pmode; msh = psh; mwb = pwb; pend = 0;
    end
  end

  // ---------------- stimulus ----------------
  int cmd_q[$];
  int addr_q[$];

  task automatic do_op(input logic [AW-1:0] a, input bit wr, input bit sh,
                       input int dly, output int cyc);
    cmd_q.delete(); addr_q.delete();
    @(negedge clk);
    lreq_valid = 1'b1; lreq_write = wr; lreq_addr = a; bus_shared_in = sh;
    cyc = 0;
    forever begin
      bus_gnt = bus_req && (cyc >= dly);
      #1;
      if (bus_cmd_valid) begin
        cmd_q.push_back(int'(bus_cmd));
        addr_q.push_back(int'(bus_addr));
      end
      if (lreq_done || cyc > 50) break;
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    lreq_valid = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       output bit sh, output bit wb);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    sh = snp_shared_out; wb = snp_wb_out;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int  cyc;
    bit  sh, wb;
    rst_n = 1'b0; lreq_valid = 1'b0; lreq_write = 1'b0; lreq_addr = '0;
    bus_gnt = 1'b0; bus_shared_in = 1'b0; snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: quiet outputs after reset
    chk(!lreq_done && !bus_req && !bus_cmd_valid, "R1", "outputs idle", int'(bus_req), 0);
    chk(!snp_shared_out && !snp_wb_out, "R1", "snoop outputs idle", int'(snp_shared_out), 0);

    // R1/R3: first read misses, no sharer -> Exclusive fill
    do_op(8'h10, 1'b0, 1'b0, 0, cyc);
    chk(cmd_q.size() == 1 && cmd_q[0] == 0, "R1", "first read uses bus read", cmd_q.size(), 1);
    chk(cyc == 2, "R3", "read miss latency", cyc, 2);
    // R2: read hit
    do_op(8'h10, 1'b0, 1'b0, 0, cyc);
    chk(cmd_q.size() == 0 && cyc == 0, "R2", "read hit", cyc, 0);
    // R4: Exclusive write upgrades silently
    do_op(8'h10, 1'b1, 1'b0, 0, cyc);
    chk(cmd_q.size() == 0 && cyc == 0, "R4", "silent write in E", cmd_q.size(), 0);
    // R6: snooped read of a Modified line
    snoop(2'd0, 8'h10, sh, wb);
    chk(sh && wb, "R6", "M snooped read shared+wb", {sh, wb}, 3);
    // R5: write to Shared -> invalidate
    do_op(8'h10, 1'b1, 1'b0, 0, cyc);
    chk(cmd_q.size() == 1 && cmd_q[0] == 2 && cyc == 1, "R5", "S write issues invalidate",
        cmd_q.size() > 0 ? cmd_q[0] : -1, 2);
    // R7: snooped RFO of a Modified line
    snoop(2'd1, 8'h10, sh, wb);
    chk(!sh && wb, "R7", "M snooped rfo", {sh, wb}, 1);
    // R7/R3: line is gone; refetch with sharer -> Shared
    do_op(8'h10, 1'b0, 1'b1, 0, cyc);
    chk(cmd_q.size() == 1 && cmd_q[0] == 0, "R7", "invalidated line refetched", cmd_q.size(), 1);
    do_op(8'h10, 1'b1, 1'b0, 0, cyc);
    chk(cmd_q.size() == 1 && cmd_q[0] == 2, "R3", "sharer fill gives S",
        cmd_q.size() > 0 ? cmd_q[0] : -1, 2);
    // R8: Modified victim written back before fetch
    do_op(8'h20, 1'b0, 1'b0, 0, cyc);
    chk(cmd_q.size() == 2 && cmd_q[0] == 3 && cmd_q[1] == 0, "R8", "wb then read",
        cmd_q.size(), 2);
    chk(addr_q.size() == 2 && addr_q[0] == 'h10 && addr_q[1] == 'h20, "R8", "victim address",
        addr_q.size() > 0 ? addr_q[0] : -1, 'h10);
    // R8: Exclusive victim dropped silently
    do_op(8'h30, 1'b0, 1'b0, 0, cyc);
    chk(cmd_q.size() == 1 && cmd_q[0] == 0, "R8", "clean victim no wb", cmd_q.size(), 1);
    // R10: snoop to a line not held, and a snooped write-back
    snoop(2'd0, 8'h20, sh, wb);
    chk(!sh && !wb, "R10", "miss snoop quiet", {sh, wb}, 0);
    snoop(2'd3, 8'h30, sh, wb);
    chk(!sh && !wb, "R10", "wb snoop quiet", {sh, wb}, 0);
    do_op(8'h30, 1'b1, 1'b0, 0, cyc);
    chk(cmd_q.size() == 0 && cyc == 0, "R10", "E kept after wb snoop", cmd_q.size(), 0);
    snoop(2'd1, 8'h31, sh, wb);
    chk(!sh && !wb, "R10", "other-slot rfo quiet", {sh, wb}, 0);
    // R5: write miss -> read-for-ownership
    do_op(8'h05, 1'b1, 1'b0, 0, cyc);
    chk(cmd_q.size() == 1 && cmd_q[0] == 1 && cyc == 1, "R5", "write miss rfo",
        cmd_q.size() > 0 ? cmd_q[0] : -1, 1);
    snoop(2'd0, 8'h05, sh, wb);
    chk(sh && wb, "R6", "rfo fill left M", {sh, wb}, 3);
    // R6: snooped read of an Exclusive line -> Shared
    do_op(8'h0B, 1'b0, 1'b0, 0, cyc);
    snoop(2'd0, 8'h0B, sh, wb);
    chk(sh && !wb, "R6", "E snooped read", {sh, wb}, 2);
    do_op(8'h0B, 1'b1, 1'b0, 0, cyc);
    chk(cmd_q.size() == 1 && cmd_q[0] == 2, "R6", "E demoted to S",
        cmd_q.size() > 0 ? cmd_q[0] : -1, 2);
    // R9: snoop to the same slot delays the granted fetch by one cycle
    fork
      do_op(8'h0A, 1'b0, 1'b0, 2, cyc);
      begin
        repeat (3) @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = 8'h1E;
        @(negedge clk);
        snp_valid = 1'b0;
      end
    join
    chk(cyc == 4, "R9", "collision stalls local request", cyc, 4);
    chk(cmd_q.size() == 1 && cmd_q[0] == 0, "R9", "retried fetch", cmd_q.size(), 1);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule